// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block sits beside one private writeback cache on a shared snooping bus and keeps that cache coherent with its peers through invalidation. It holds a small direct-mapped array of tags, MESI states and line data. It serves processor loads and stores. When a miss or an ownership upgrade needs the bus, it issues a read (for a load) or a read-for-ownership (for a store). Before refilling over a dirty victim, it writes that victim back.

At the same time it watches every transaction that other caches put on the bus. A snooped read that hits a valid line makes it drive its contribution to a wired-OR shared line. A requester samples that line during its own read to choose between a Shared fill and an Exclusive fill. A cache holding an Exclusive line can then store into it with no bus traffic at all.

Cache-to-cache data supply is decided locally. Every hitting cache raises a candidacy bit. All candidacy bits are gathered into a vector seen by every controller, and the lowest-numbered candidate is the one allowed to drive the data.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: `cpu_ack_o`, `bus_req_o`, `shared_o`, `sup_cand_o` and `flush_o` are low, and a snoop to any address gets no response.
- R2: A load miss issues a bus read (`bus_cmd_o` = 1) to the requested address. The cycle where `bus_gnt_i` is high completes the fill. If `bus_shared_i` is high in that cycle the line fills Shared, otherwise Exclusive, and the fill data is returned on `cpu_rdata_o` with `cpu_ack_o` one cycle after the grant.
- R3: A store to an Exclusive line completes with no bus request and leaves the line Modified.
- R4: A store to a Shared or Invalid line issues a read-for-ownership (`bus_cmd_o` = 2) to the address, and the line becomes Modified holding the store data.
- R5: A load that hits a Modified, Exclusive or Shared line, or a store that hits a Modified line, completes with no bus request. A load returns the line's current data.
- R6: A snooped read (`snp_cmd_i` = 1) that hits a valid line raises `shared_o` in the same cycle. With no snoop, or on a snoop miss, `shared_o` stays low.
- R7: A snooped read that hits a Modified or Exclusive line raises `flush_o` with the line data on `bus_data_o`, and the line becomes Shared.
- R8: A snooped read-for-ownership (`snp_cmd_i` = 2) that hits a Modified or Exclusive line flushes the data. A snooped read-for-ownership that hits any valid line leaves it Invalid.
- R9: Any snoop hit on a valid line raises `sup_cand_o`. On a Shared line the controller flushes only when its own bit is the lowest set bit of `sup_vec_i`. Otherwise it only updates state.
- R10: A miss whose indexed line is Modified with another tag first issues a write-back (`bus_cmd_o` = 3) carrying the victim address and data, then the fill. If the victim stops being Modified before its write-back is granted, the write-back is dropped. A clean victim is replaced with no write-back.
- R11: A processor request is not accepted in a cycle where `snp_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until acknowledged |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Load data, valid with the acknowledge |
| bus_req_o | output | 1 | Request for the bus |
| bus_cmd_o | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr_o | output | ADDR_W | Address of the issued transaction |
| bus_data_o | output | DATA_W | Write-back data, or flushed line data when `flush_o` is high |
| bus_gnt_i | input | 1 | Transaction completes this cycle |
| bus_shared_i | input | 1 | Wired-OR shared line, sampled on an own read grant |
| bus_fill_i | input | DATA_W | Line data for an own granted read or read-for-ownership |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as `bus_cmd_o` |
| snp_addr_i | input | ADDR_W | Snooped address |
| shared_o | output | 1 | Contribution to the wired-OR shared line |
| sup_cand_o | output | 1 | This cache can supply the snooped line |
| sup_vec_i | input | N_CACHES | Candidacy bits of all caches, index = cache number |
| flush_o | output | 1 | This cache drives the snooped line's data |

## Verification
The assertions check several rules on every cycle:
- a granted fill is acknowledged on the next cycle;
- a store hit on an Exclusive line raises no bus request;
- a snooped read hit always raises the shared output;
- a read-for-ownership hit on a Modified or Exclusive line always flushes;
- a Shared line flushes only while its own candidacy bit is set;
- an idle controller drives neither request nor acknowledge.

Some behaviour shows up only across whole transaction sequences, so only the bench scenarios can reveal it. This covers the choice between Exclusive and Shared fills, the ordering of write-back before fill, and the dropped write-back when a snoop takes the victim while it waits for the bus. It also covers the lowest-number supplier rule with candidates above and below this cache, and the state left behind after each snoop, which is exposed by the bus traffic that the next access does or does not raise.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RD   = 2'd1,
    CMD_RDX  = 2'd2,
    CMD_WB   = 2'd3
  } bus_cmd_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_WB   = 2'd1,
    C_FILL = 2'd2,
    C_RESP = 2'd3
  } ctl_e;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor-side port
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [TAG_W-1:0]  a_tag_o,
  output mesi_e             a_st_o,
  output logic [DATA_W-1:0] a_dat_o,
  // snoop-side port
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [TAG_W-1:0]  b_tag_o,
  output mesi_e             b_st_o,
  output logic [DATA_W-1:0] b_dat_o,
  // full line write
  input  logic              line_we_i,
  input  logic [IDX_W-1:0]  line_idx_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  mesi_e             line_st_i,
  input  logic [DATA_W-1:0] line_dat_i,
  // state-only write (snoop), wins over a line write
  input  logic              st_we_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  mesi_e             st_val_i
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_q [LINES];
  mesi_e             st_q  [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q[g] <= '0;
        st_q[g]  <= ST_I;
        dat_q[g] <= '0;
      end else begin
        if (line_we_i && line_idx_i == IDX_W'(g)) begin
          tag_q[g] <= line_tag_i;
          st_q[g]  <= line_st_i;
          dat_q[g] <= line_dat_i;
        end
        if (st_we_i && st_idx_i == IDX_W'(g)) st_q[g] <= st_val_i;
      end
    end
  end

  assign a_tag_o = tag_q[a_idx_i];
  assign a_st_o  = st_q[a_idx_i];
  assign a_dat_o = dat_q[a_idx_i];
  assign b_tag_o = tag_q[b_idx_i];
  assign b_st_o  = st_q[b_idx_i];
  assign b_dat_o = dat_q[b_idx_i];

endmodule

// File: rtl/mesi_sup_select.sv
module mesi_sup_select #(
  parameter int N_CACHES = 4,
  parameter int CACHE_ID = 0
) (
  input  logic [N_CACHES-1:0] vec_i,
  output logic                sel_o
);
  localparam logic [N_CACHES-1:0] LOW_MASK =
    N_CACHES'((64'd1 << CACHE_ID) - 64'd1);

  // lowest-numbered candidate wins
  assign sel_o = vec_i[CACHE_ID] && ((vec_i & LOW_MASK) == '0);

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
(
  input  logic       snp_valid_i,
  input  logic [1:0] snp_cmd_i,
  input  logic       hit_i,
  input  mesi_e      line_st_i,
  input  logic       sel_i,
  output logic       shared_o,
  output logic       cand_o,
  output logic       flush_o,
  output logic       upd_we_o,
  output mesi_e      upd_st_o
);
  logic rd_hit, rdx_hit, owner;

  assign rd_hit  = snp_valid_i && (snp_cmd_i == CMD_RD)  && hit_i;
  assign rdx_hit = snp_valid_i && (snp_cmd_i == CMD_RDX) && hit_i;
  assign owner   = (line_st_i == ST_M) || (line_st_i == ST_E);

  assign shared_o = rd_hit;
  assign cand_o   = rd_hit || rdx_hit;
  assign flush_o  = (rd_hit || rdx_hit) && (owner || (line_st_i == ST_S && sel_i));
  assign upd_we_o = (rd_hit && owner) || rdx_hit;
  assign upd_st_o = rdx_hit ? ST_I : ST_S;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 3,
  parameter int N_CACHES = 4,
  parameter int CACHE_ID = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_req_i,
  input  logic                cpu_we_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic                cpu_ack_o,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                bus_req_o,
  output logic [1:0]          bus_cmd_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_data_o,
  input  logic                bus_gnt_i,
  input  logic                bus_shared_i,
  input  logic [DATA_W-1:0]   bus_fill_i,
  input  logic                snp_valid_i,
  input  logic [1:0]          snp_cmd_i,
  input  logic [ADDR_W-1:0]   snp_addr_i,
  output logic                shared_o,
  output logic                sup_cand_o,
  input  logic [N_CACHES-1:0] sup_vec_i,
  output logic                flush_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  ctl_e              st_q, st_d;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic [IDX_W-1:0]  a_idx, b_idx;
  logic [TAG_W-1:0]  req_tag, a_tag, b_tag;
  mesi_e             a_st, b_st;
  logic [DATA_W-1:0] a_dat, b_dat;
  logic              hit_a, hit_b;

  logic              line_we;
  logic [TAG_W-1:0]  line_tag;
  mesi_e             line_st;
  logic [DATA_W-1:0] line_dat;
  logic              snp_we;
  mesi_e             snp_st;
  logic              sup_sel;
  logic              accept;
  bus_cmd_e          cmd;

  assign a_idx   = (st_q == C_IDLE) ? cpu_addr_i[IDX_W-1:0] : addr_q[IDX_W-1:0];
  assign req_tag = (st_q == C_IDLE) ? cpu_addr_i[ADDR_W-1:IDX_W] : addr_q[ADDR_W-1:IDX_W];
  assign b_idx   = snp_addr_i[IDX_W-1:0];
  assign hit_a   = (a_st != ST_I) && (a_tag == req_tag);
  assign hit_b   = (b_st != ST_I) && (b_tag == snp_addr_i[ADDR_W-1:IDX_W]);

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .a_idx_i(a_idx), .a_tag_o(a_tag), .a_st_o(a_st), .a_dat_o(a_dat),
    .b_idx_i(b_idx), .b_tag_o(b_tag), .b_st_o(b_st), .b_dat_o(b_dat),
    .line_we_i(line_we), .line_idx_i(a_idx), .line_tag_i(line_tag),
    .line_st_i(line_st), .line_dat_i(line_dat),
    .st_we_i(snp_we), .st_idx_i(b_idx), .st_val_i(snp_st)
  );

  mesi_sup_select #(.N_CACHES(N_CACHES), .CACHE_ID(CACHE_ID)) u_sel (
    .vec_i(sup_vec_i), .sel_o(sup_sel)
  );

  mesi_snoop_resp u_snoop (
    .snp_valid_i, .snp_cmd_i, .hit_i(hit_b), .line_st_i(b_st), .sel_i(sup_sel),
    .shared_o, .cand_o(sup_cand_o), .flush_o,
    .upd_we_o(snp_we), .upd_st_o(snp_st)
  );

  always_comb begin
    st_d       = st_q;
    accept     = 1'b0;
    line_we    = 1'b0;
    line_tag   = req_tag;
    line_st    = ST_I;
    line_dat   = a_dat;
    bus_req_o  = 1'b0;
    cmd        = CMD_NONE;
    bus_addr_o = {req_tag, a_idx};
    unique case (st_q)
      C_IDLE: begin
        // snoop owns the array this cycle (R11)
        if (cpu_req_i && !snp_valid_i) begin
          accept = 1'b1;
          if (!cpu_we_i && hit_a) begin
            st_d = C_RESP;
          end else if (cpu_we_i && hit_a && (a_st == ST_M || a_st == ST_E)) begin
            line_we  = 1'b1;
            line_st  = ST_M;
            line_dat = cpu_wdata_i;
            st_d     = C_RESP;
          end else if (!hit_a && a_st == ST_M) begin
            st_d = C_WB;
          end else begin
            st_d = C_FILL;
          end
        end
      end
      C_WB: begin
        if (a_st != ST_M) begin
          st_d = C_FILL;  // victim taken by a snoop, nothing left to write
        end else begin
          bus_req_o  = 1'b1;
          cmd        = CMD_WB;
          bus_addr_o = {a_tag, a_idx};
          if (bus_gnt_i) begin
            line_we  = 1'b1;
            line_tag = a_tag;
            line_st  = ST_I;
            st_d     = C_FILL;
          end
        end
      end
      C_FILL: begin
        bus_req_o = 1'b1;
        cmd       = we_q ? CMD_RDX : CMD_RD;
        if (bus_gnt_i) begin
          line_we  = 1'b1;
          line_st  = we_q ? ST_M : (bus_shared_i ? ST_S : ST_E);
          line_dat = we_q ? wdata_q : bus_fill_i;
          st_d     = C_RESP;
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= C_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        we_q    <= cpu_we_i;
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
        if (!cpu_we_i && hit_a) rdata_q <= a_dat;
      end
      if (st_q == C_FILL && bus_gnt_i && !we_q) rdata_q <= bus_fill_i;
    end
  end

  assign bus_cmd_o   = cmd;
  assign bus_data_o  = flush_o ? b_dat : a_dat;
  assign cpu_ack_o   = (st_q == C_RESP);
  assign cpu_rdata_o = rdata_q;

  // R1: an idle controller neither requests nor acknowledges
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_IDLE) |-> (!bus_req_o && !cpu_ack_o));

  // R2: a granted fill is acknowledged on the next cycle
  p_fill_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_FILL && bus_gnt_i) |=> cpu_ack_o);

  // R3: a store hit on Exclusive is silent
  p_silent_upgrade_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_IDLE && cpu_req_i && cpu_we_i && !snp_valid_i && hit_a && a_st == ST_E)
    |=> (cpu_ack_o && !bus_req_o));

  // R6: a snooped read hit raises the shared line
  p_shared_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RD && hit_b) |-> shared_o);

  // R8: ownership snoop on an owned line must flush
  p_rdx_owner_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_valid_i && snp_cmd_i == CMD_RDX && hit_b && (b_st == ST_M || b_st == ST_E))
    |-> flush_o);

  // R9: a Shared holder flushes only while a candidate itself
  p_shared_supplier_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && b_st == ST_S) |-> sup_vec_i[CACHE_ID]);

  // R10: a granted write-back is followed by the fill request
  p_wb_then_fill_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_WB && bus_req_o && bus_gnt_i)
    |=> (st_q == C_FILL && bus_req_o && bus_cmd_o != CMD_WB));

  // environment: own grant and foreign snoop never coincide
  p_gnt_snoop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_gnt_i && snp_valid_i));

endmodule

// File: tb/sim_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_snoop_ctrl;
  localparam int AW = 12, DW = 16, IW = 3, NC = 4, ID = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic gnt = 0, shr = 0;
  logic [DW-1:0] fill = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;
  logic shared, sup_cand, flush;
  logic [NC-1:0] oth = '0;
  logic [NC-1:0] sup_vec;

  assign sup_vec = {oth[3], sup_cand, oth[1:0]};

  always #4 clk_i = ~clk_i;

  mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .N_CACHES(NC), .CACHE_ID(ID)) u0 (
    .clk_i, .rst_ni,
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr), .bus_data_o(bus_data),
    .bus_gnt_i(gnt), .bus_shared_i(shr), .bus_fill_i(fill),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
    .shared_o(shared), .sup_cand_o(sup_cand), .sup_vec_i(sup_vec), .flush_o(flush)
  );

  int n_chk = 0, n_bad = 0;

  // reference model: 0=I 1=S 2=E 3=M
  int            m_st  [8];
  logic [AW-IW-1:0] m_tag [8];
  logic [DW-1:0] m_dat [8];
  logic [DW-1:0] mem [int];

  function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : (DW'(a) ^ 16'h5A3C);
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // quiet snoop outputs whenever no snoop is driven (R6, R9)
  always begin
    @(negedge clk_i); #2;
    if (rst_ni && !snp_valid)
      chk(!shared && !flush && !sup_cand, "R6", "snoop outputs without snoop",
          {shared, flush, sup_cand}, 0);
  end

  task automatic cpu_op(bit we, logic [AW-1:0] a, logic [DW-1:0] wd, bit s, string rq);
    int idx = int'(a[IW-1:0]);
    logic [AW-IW-1:0] tg = a[AW-1:IW];
    bit hit = (m_st[idx] != 0) && (m_tag[idx] == tg);
    bit exp_wb = 0;
    int exp_n = 0, seen = 0;
    logic [1:0] exp_cmd = we ? 2'd2 : 2'd1;
    logic [AW-1:0] vaddr = {m_tag[idx], a[IW-1:0]};
    logic [DW-1:0] vdat = m_dat[idx];
    logic [DW-1:0] exp_rd = m_dat[idx];
    bit done = 0;
    if (!we && hit) exp_n = 0;
    else if (we && hit && m_st[idx] >= 2) begin
      exp_n = 0; m_st[idx] = 3; m_dat[idx] = wd;
    end else begin
      exp_wb = !hit && m_st[idx] == 3;
      exp_n  = exp_wb ? 2 : 1;
    end
    @(negedge clk_i);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    for (int t = 0; t < 40 && !done; t++) begin
      @(negedge clk_i); #1;
      if (gnt) gnt = 0;
      else if (bus_req) begin
        if (exp_wb && seen == 0) begin
          chk(bus_cmd == 2'd3, "R10", "write-back cmd", bus_cmd, 3);
          chk(bus_addr == vaddr, "R10", "write-back addr", bus_addr, vaddr);
          chk(bus_data == vdat, "R10", "write-back data", bus_data, vdat);
          mem[int'(vaddr)] = vdat;
        end else begin
          chk(bus_cmd == exp_cmd, rq, "bus cmd", bus_cmd, exp_cmd);
          chk(bus_addr == a, rq, "bus addr", bus_addr, a);
          shr = s; fill = mem_rd(a);
        end
        seen++;
        gnt = 1;
      end
      if (cpu_ack) begin
        done = 1;
        cpu_req = 0;
      end
    end
    chk(done, rq, "acknowledge", done, 1);
    chk(seen == exp_n, rq, "bus transactions", seen, exp_n);
    if (exp_n > 0) begin
      m_tag[idx] = tg;
      if (we) begin m_st[idx] = 3; m_dat[idx] = wd; end
      else begin m_st[idx] = s ? 1 : 2; m_dat[idx] = mem_rd(a); exp_rd = mem_rd(a); end
    end
    if (!we) chk(cpu_rdata == exp_rd, rq, "load data", cpu_rdata, exp_rd);
  endtask

  task automatic snoop(logic [1:0] c, logic [AW-1:0] a, logic [NC-1:0] o, string rq);
    int idx = int'(a[IW-1:0]);
    bit hit, sel, e_fl;
    @(negedge clk_i);
    snp_valid = 1; snp_cmd = c; snp_addr = a; oth = o;
    #1;
    hit  = (m_st[idx] != 0) && (m_tag[idx] == a[AW-1:IW]);
    sel  = hit && (o[1:0] == 2'b00);
    e_fl = hit && (m_st[idx] >= 2 || (m_st[idx] == 1 && sel));
    chk(shared == (hit && c == 2'd1), rq, "shared_o", shared, hit && c == 2'd1);
    chk(sup_cand == hit, rq, "sup_cand_o", sup_cand, hit);
    chk(flush == e_fl, rq, "flush_o", flush, e_fl);
    if (e_fl) chk(bus_data == m_dat[idx], rq, "flush data", bus_data, m_dat[idx]);
    if (hit) begin
      if (m_st[idx] == 3) mem[int'(a)] = m_dat[idx];
      if (c == 2'd2) m_st[idx] = 0;
      else if (m_st[idx] >= 2) m_st[idx] = 1;
    end
    @(negedge clk_i);
    snp_valid = 0; oth = '0;
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(!cpu_ack && !bus_req && !shared && !flush && !sup_cand, "R1", "reset outputs",
        {cpu_ack, bus_req, shared, flush, sup_cand}, 0);
    for (int i = 0; i < 8; i++) snoop(2'd1, AW'(12'h050 + i), 4'b0000, "R1");

    // Exclusive fill, silent store, Modified hits
    cpu_op(0, 12'h011, '0, 0, "R2");
    cpu_op(0, 12'h011, '0, 0, "R5");
    cpu_op(1, 12'h011, 16'hBEEF, 0, "R3");
    cpu_op(0, 12'h011, '0, 0, "R5");
    cpu_op(1, 12'h011, 16'h1234, 0, "R5");

    // snooped read on Modified, then ownership upgrade from Shared
    snoop(2'd1, 12'h011, 4'b0000, "R7");
    cpu_op(1, 12'h011, 16'h7777, 0, "R4");
    snoop(2'd2, 12'h011, 4'b0000, "R8");
    cpu_op(0, 12'h011, '0, 1, "R2");

    // supplier selection on Shared lines
    snoop(2'd2, 12'h011, 4'b0010, "R9");
    cpu_op(0, 12'h011, '0, 1, "R8");
    snoop(2'd2, 12'h011, 4'b1000, "R9");
    snoop(2'd1, 12'h011, 4'b0000, "R6");

    cpu_op(0, 12'h022, '0, 0, "R2");
    snoop(2'd1, 12'h022, 4'b0000, "R7");
    snoop(2'd1, 12'h022, 4'b0001, "R9");
    snoop(2'd1, 12'h022, 4'b1000, "R9");
    cpu_op(0, 12'h022, '0, 0, "R5");

    // victim handling
    cpu_op(1, 12'h033, 16'hCAFE, 0, "R4");
    cpu_op(0, 12'h0B3, '0, 0, "R10");
    cpu_op(0, 12'h0A2, '0, 1, "R10");

    // request held during a snoop is not taken until the snoop ends (R11)
    @(negedge clk_i);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 12'h0F7;
    cpu_req = 1; cpu_we = 0; cpu_addr = 12'h0B3;
    @(negedge clk_i); #1;
    chk(!cpu_ack && !bus_req, "R11", "request taken during snoop", {cpu_ack, bus_req}, 0);
    snp_valid = 0;
    @(negedge clk_i); #1;
    chk(cpu_ack && cpu_rdata == m_dat[3], "R11", "held load after snoop", cpu_rdata, m_dat[3]);
    cpu_req = 0;

    // write-back dropped when a snoop takes the dirty victim
    cpu_op(1, 12'h044, 16'hD00D, 0, "R4");
    begin
      bit got_wb = 0, done = 0;
      int rds = 0;
      @(negedge clk_i);
      cpu_req = 1; cpu_we = 0; cpu_addr = 12'h0C4;
      for (int t = 0; t < 10 && !got_wb; t++) begin
        @(negedge clk_i); #1;
        if (bus_req) got_wb = 1;
      end
      chk(got_wb && bus_cmd == 2'd3, "R10", "pending write-back", bus_cmd, 3);
      snp_valid = 1; snp_cmd = 2'd2; snp_addr = 12'h044;
      #1;
      chk(flush && bus_data == 16'hD00D, "R8", "flush of waiting victim", bus_data, 16'hD00D);
      mem[32'h044] = 16'hD00D;
      m_st[4] = 0;
      @(negedge clk_i);
      snp_valid = 0;
      #1;
      chk(!bus_req, "R10", "write-back dropped", bus_req, 0);
      for (int t = 0; t < 20 && !done; t++) begin
        @(negedge clk_i); #1;
        if (gnt) gnt = 0;
        else if (bus_req) begin
          chk(bus_cmd == 2'd1 && bus_addr == 12'h0C4, "R10", "fill after drop", bus_cmd, 1);
          rds++; shr = 0; fill = mem_rd(12'h0C4); gnt = 1;
        end
        if (cpu_ack) begin done = 1; cpu_req = 0; end
      end
      chk(done && rds == 1, "R10", "single fill", rds, 1);
      chk(cpu_rdata == mem_rd(12'h0C4), "R10", "load data", cpu_rdata, mem_rd(12'h0C4));
      m_st[4] = 2; m_tag[4] = 12'h0C4 >> IW; m_dat[4] = mem_rd(12'h0C4);
    end
    cpu_op(1, 12'h0C4, 16'h4242, 0, "R3");
    cpu_op(0, 12'h044, '0, 0, "R10");

    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule